// File: doc/BRIEF.md
# State-Enable Control Register Hierarchy

This unit holds, for one hart, the three tiers of registers that decide whether code running below machine mode may touch the architectural state of optional extensions. There are four machine-tier registers and four hypervisor-tier registers, each 64 bits wide, and four supervisor-tier registers, each 32 bits wide. A single CSR port takes a 12-bit address, 64-bit write data, a write strobe and the current privilege mode. It returns read data at once, and flags an access that must trap as an illegal-instruction or a virtual-instruction case. Trap delivery is left to the pipeline.

A lower tier can never grant more than the tier above it. A bit that is clear in a machine-tier register is stored and read as zero in the matching hypervisor-tier and supervisor-tier registers. When the access comes from a virtualized supervisor, a bit that is clear in the hypervisor tier is also masked out of the supervisor tier. The read masking is combinational, so clearing a higher-tier bit hides the lower-tier bit at once, without a rewrite.

A separate query port takes a privilege mode and a register index. It returns the per-bit "state reachable" vector that the extension logic uses to decide whether an instruction may run.

Top module: `stateen_ctrl`

## Requirements
- R1: After reset every enable register holds zero, so every address in the three tiers reads zero and the query vector is zero for every mode except M.
- R2: Machine-tier registers sit at 0x30C+i (i = 0..3) and are written and read as full 64-bit values from M-mode (priv_mode code 3). From any other mode the access raises csr_illegal, returns zero and does not change the register.
- R3: Hypervisor-tier registers sit at 0x60C+i. A write stores csr_wdata AND machine register i. A read returns the stored value AND the current machine register i, so clearing a machine bit hides the hypervisor bit on the next read.
- R4: A hypervisor-tier access from VS (code 5) or VU (code 4) raises csr_virtual. From U (code 0) it raises csr_illegal. In both cases the read returns zero and the write is dropped. S (code 1), HS (code 2) and M may access it.
- R5: Supervisor-tier registers sit at 0x10C+i and hold 32 bits. A write from S, HS or M stores csr_wdata[31:0] AND machine register i[31:0]. A read from those modes returns the stored value AND the current machine register i, with bits 63:32 always zero.
- R6: From VS-mode, supervisor-tier writes are also ANDed with hypervisor register i, and reads are also masked by the current hypervisor register i.
- R7: A supervisor-tier access from U raises csr_illegal and from VU raises csr_virtual. Either way the read returns zero and the write is dropped.
- R8: The qry_allow vector for index i is computed per qry_mode from the effective registers (hypervisor-tier bits masked by machine register i, supervisor-tier bits zero-extended):
  - M: all ones.
  - S or HS: machine register i.
  - VS: machine AND hypervisor register i.
  - VU: machine AND hypervisor AND supervisor register i.
  - U: machine AND supervisor register i.
- R9: Any address outside the three 4-entry windows reads zero, raises neither flag, and a write to it changes no register.
- R10: priv_mode and qry_mode codes 6 and 7 behave exactly as U-mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | 12 | CSR address of the current access |
| csr_wdata | input | 64 | Write data |
| csr_we | input | 1 | Write strobe; the write lands on the next rising edge |
| priv_mode | input | 3 | Mode of the access: 0 U, 1 S, 2 HS, 3 M, 4 VU, 5 VS |
| csr_rdata | output | 64 | Masked read data for csr_addr (zero on a fault) |
| csr_illegal | output | 1 | Access must raise an illegal-instruction trap |
| csr_virtual | output | 1 | Access must raise a virtual-instruction trap |
| qry_mode | input | 3 | Mode for the accessibility query, same encoding |
| qry_idx | input | 2 | Register index for the query |
| qry_allow | output | 64 | Per-bit state-reachable vector |

## Verification
The bench goes after the masking corner cases.

- It clears a machine bit after lower tiers were written with ones. A design that masked only at write time would then still show the old hypervisor or supervisor bit.
- It writes the supervisor tier from VS and from S with the same data and compares the two. A design that skipped the hypervisor AND, or applied it outside VS, would store the wrong value.
- It sends writes that must fault from every disallowed mode, and to unmapped neighbours of each window, then reads the target back. A leaking write enable would show up there.
- It sweeps the query port over all eight mode codes. A design that included the wrong tiers for VU or U, or treated codes 6 and 7 as privileged, would produce a different vector.

// File: rtl/stateen_pkg.sv
package stateen_pkg;

  typedef enum logic [2:0] {
    MODE_U  = 3'd0,
    MODE_S  = 3'd1,
    MODE_HS = 3'd2,
    MODE_M  = 3'd3,
    MODE_VU = 3'd4,
    MODE_VS = 3'd5
  } mode_e;

  typedef enum logic [1:0] {
    TIER_NONE = 2'd0,
    TIER_M    = 2'd1,
    TIER_H    = 2'd2,
    TIER_S    = 2'd3
  } tier_e;

  // Unused encodings fold onto the least privileged mode.
  function automatic mode_e norm_mode(input logic [2:0] raw);
    case (raw)
      3'd1:    return MODE_S;
      3'd2:    return MODE_HS;
      3'd3:    return MODE_M;
      3'd4:    return MODE_VU;
      3'd5:    return MODE_VS;
      default: return MODE_U;
    endcase
  endfunction

  function automatic logic is_guest(input mode_e m);
    return (m == MODE_VS) || (m == MODE_VU);
  endfunction

endpackage

// File: rtl/stateen_decode.sv
module stateen_decode
  import stateen_pkg::*;
#(
  parameter int          IDXW   = 2,
  parameter logic [11:0] M_BASE = 12'h30C,
  parameter logic [11:0] H_BASE = 12'h60C,
  parameter logic [11:0] S_BASE = 12'h10C
) (
  input  logic [11:0]     addr,
  input  mode_e           mode,
  output tier_e           tier,
  output logic [IDXW-1:0] idx,
  output logic            ill,
  output logic            virt
);

  always_comb begin
    idx  = addr[IDXW-1:0];
    tier = TIER_NONE;
    ill  = 1'b0;
    virt = 1'b0;
    if (addr[11:IDXW] == M_BASE[11:IDXW]) begin
      tier = TIER_M;
      ill  = (mode != MODE_M);
    end else if (addr[11:IDXW] == H_BASE[11:IDXW]) begin
      tier = TIER_H;
      virt = is_guest(mode);
      ill  = (mode == MODE_U);
    end else if (addr[11:IDXW] == S_BASE[11:IDXW]) begin
      tier = TIER_S;
      virt = (mode == MODE_VU);
      ill  = (mode == MODE_U);
    end
  end

endmodule

// File: rtl/stateen_bank.sv
module stateen_bank #(
  parameter int NREG = 4,
  parameter int W    = 64,
  parameter int IDXW = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDXW-1:0]   widx,
  input  logic [W-1:0]      wdata,
  output logic [NREG*W-1:0] regs_flat
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs_flat[g*W +: W] <= '0;
      else if (we && (widx == IDXW'(g)))
        regs_flat[g*W +: W] <= wdata;
    end
  end

endmodule

// File: rtl/stateen_gate.sv
module stateen_gate
  import stateen_pkg::*;
#(
  parameter int NREG  = 4,
  parameter int XLEN  = 64,
  parameter int SXLEN = 32,
  parameter int IDXW  = $clog2(NREG)
) (
  input  logic [NREG*XLEN-1:0]  m_flat,
  input  logic [NREG*XLEN-1:0]  h_flat,
  input  logic [NREG*SXLEN-1:0] s_flat,
  input  mode_e                 q_mode,
  input  logic [IDXW-1:0]       q_idx,
  output logic [XLEN-1:0]       allow
);

  logic [XLEN-1:0] m_q, h_q, s_q;

  assign m_q = m_flat[q_idx*XLEN +: XLEN];
  assign h_q = h_flat[q_idx*XLEN +: XLEN];
  assign s_q = {{(XLEN-SXLEN){1'b0}}, s_flat[q_idx*SXLEN +: SXLEN]};

  // Each tier strictly above the mode contributes its enable bits.
  always_comb begin
    case (q_mode)
      MODE_M:          allow = '1;
      MODE_S, MODE_HS: allow = m_q;
      MODE_VS:         allow = m_q & h_q;
      MODE_VU:         allow = m_q & h_q & s_q;
      default:         allow = m_q & s_q;
    endcase
  end

endmodule

// File: rtl/stateen_ctrl.sv
module stateen_ctrl
  import stateen_pkg::*;
#(
  parameter int          NREG   = 4,
  parameter int          XLEN   = 64,
  parameter int          SXLEN  = 32,
  parameter int          IDXW   = $clog2(NREG),
  parameter logic [11:0] M_BASE = 12'h30C,
  parameter logic [11:0] H_BASE = 12'h60C,
  parameter logic [11:0] S_BASE = 12'h10C
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic            csr_we,
  input  logic [2:0]      priv_mode,
  output logic [XLEN-1:0] csr_rdata,
  output logic            csr_illegal,
  output logic            csr_virtual,
  input  logic [2:0]      qry_mode,
  input  logic [IDXW-1:0] qry_idx,
  output logic [XLEN-1:0] qry_allow
);

  localparam logic [XLEN-1:0] S_SPAN = {{(XLEN-SXLEN){1'b0}}, {SXLEN{1'b1}}};

  // Mask applied to the supervisor tier, on writes and on reads alike.
  function automatic logic [XLEN-1:0] sup_mask(input logic [XLEN-1:0] m,
                                               input logic [XLEN-1:0] h,
                                               input logic guest);
    return m & (guest ? h : '1) & S_SPAN;
  endfunction

  // Named internal events for the checker.
  mode_e                  mode_n;
  mode_e                  qmode_n;
  tier_e                  tier;
  logic [IDXW-1:0]        idx;
  logic                   fault;
  logic                   wr_commit;
  logic                   vs_access;
  logic [XLEN-1:0]        m_sel, h_sel, s_sel;
  logic [XLEN-1:0]        s_lim;
  logic [XLEN-1:0]        wr_val;
  logic [NREG*XLEN-1:0]   m_flat, h_flat;
  logic [NREG*SXLEN-1:0]  s_flat;

  assign mode_n    = norm_mode(priv_mode);
  assign qmode_n   = norm_mode(qry_mode);
  assign vs_access = (mode_n == MODE_VS);

  stateen_decode #(
    .IDXW(IDXW), .M_BASE(M_BASE), .H_BASE(H_BASE), .S_BASE(S_BASE)
  ) u_dec (
    .addr (csr_addr),
    .mode (mode_n),
    .tier (tier),
    .idx  (idx),
    .ill  (csr_illegal),
    .virt (csr_virtual)
  );

  assign fault     = csr_illegal | csr_virtual;
  assign wr_commit = csr_we & (tier != TIER_NONE) & ~fault;

  assign m_sel = m_flat[idx*XLEN +: XLEN];
  assign h_sel = h_flat[idx*XLEN +: XLEN];
  assign s_sel = {{(XLEN-SXLEN){1'b0}}, s_flat[idx*SXLEN +: SXLEN]};
  assign s_lim = sup_mask(m_sel, h_sel, vs_access);

  always_comb begin
    case (tier)
      TIER_H:  wr_val = csr_wdata & m_sel;
      TIER_S:  wr_val = csr_wdata & s_lim;
      default: wr_val = csr_wdata;
    endcase
  end

  stateen_bank #(.NREG(NREG), .W(XLEN), .IDXW(IDXW)) u_mbank (
    .clk(clk), .rst_n(rst_n), .we(wr_commit && tier == TIER_M),
    .widx(idx), .wdata(wr_val), .regs_flat(m_flat)
  );

  stateen_bank #(.NREG(NREG), .W(XLEN), .IDXW(IDXW)) u_hbank (
    .clk(clk), .rst_n(rst_n), .we(wr_commit && tier == TIER_H),
    .widx(idx), .wdata(wr_val), .regs_flat(h_flat)
  );

  stateen_bank #(.NREG(NREG), .W(SXLEN), .IDXW(IDXW)) u_sbank (
    .clk(clk), .rst_n(rst_n), .we(wr_commit && tier == TIER_S),
    .widx(idx), .wdata(wr_val[SXLEN-1:0]), .regs_flat(s_flat)
  );

  always_comb begin
    if (fault) begin
      csr_rdata = '0;
    end else begin
      case (tier)
        TIER_M:  csr_rdata = m_sel;
        TIER_H:  csr_rdata = h_sel & m_sel;
        TIER_S:  csr_rdata = s_sel & s_lim;
        default: csr_rdata = '0;
      endcase
    end
  end

  stateen_gate #(
    .NREG(NREG), .XLEN(XLEN), .SXLEN(SXLEN), .IDXW(IDXW)
  ) u_gate (
    .m_flat (m_flat),
    .h_flat (h_flat),
    .s_flat (s_flat),
    .q_mode (qmode_n),
    .q_idx  (qry_idx),
    .allow  (qry_allow)
  );

endmodule

// File: rtl/stateen_ctrl_chk.sv
module stateen_ctrl_chk
  import stateen_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int SXLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input mode_e           mode_n,
  input mode_e           qmode_n,
  input tier_e           tier,
  input logic            ill,
  input logic            virt,
  input logic            wr_commit,
  input logic [XLEN-1:0] rdata,
  input logic [XLEN-1:0] m_sel,
  input logic [XLEN-1:0] allow
);

  localparam logic [XLEN-1:0] LOW_SPAN = {{(XLEN-SXLEN){1'b0}}, {SXLEN{1'b1}}};

  p_mtier_priv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tier == TIER_M && mode_n != MODE_M) |-> (ill && rdata == '0));

  p_fault_blocks_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ill || virt) |-> !wr_commit);

  p_htier_guest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tier == TIER_H && (mode_n == MODE_VS || mode_n == MODE_VU)) |-> (virt && !ill));

  p_sread_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tier == TIER_S && !ill && !virt) |-> ((rdata & ~(m_sel & LOW_SPAN)) == '0));

  p_stier_user_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tier == TIER_S && mode_n == MODE_U) |-> (ill && rdata == '0));

  p_mode_m_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (qmode_n == MODE_M) |-> (&allow));

  p_unmapped_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tier == TIER_NONE) |-> (rdata == '0 && !ill && !virt && !wr_commit));

endmodule

bind stateen_ctrl stateen_ctrl_chk #(.XLEN(XLEN), .SXLEN(SXLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_n    (mode_n),
  .qmode_n   (qmode_n),
  .tier      (tier),
  .ill       (csr_illegal),
  .virt      (csr_virtual),
  .wr_commit (wr_commit),
  .rdata     (csr_rdata),
  .m_sel     (m_sel),
  .allow     (qry_allow)
);

// File: tb/tb_stateen_ctrl.sv
`timescale 1ns/1ps
module tb_stateen_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [63:0] csr_wdata = '0;
  logic        csr_we = 1'b0;
  logic [2:0]  priv_mode = 3'd3;
  logic [63:0] csr_rdata;
  logic        csr_illegal, csr_virtual;
  logic [2:0]  qry_mode = 3'd3;
  logic [1:0]  qry_idx = '0;
  logic [63:0] qry_allow;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // Behavioural model state.
  logic [63:0] mdl_m [4];
  logic [63:0] mdl_h [4];
  logic [31:0] mdl_s [4];

  always #4 clk = ~clk;

  stateen_ctrl dut (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_we(csr_we), .priv_mode(priv_mode), .csr_rdata(csr_rdata),
    .csr_illegal(csr_illegal), .csr_virtual(csr_virtual),
    .qry_mode(qry_mode), .qry_idx(qry_idx), .qry_allow(qry_allow)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [11:0] a, input logic [2:0] md);
    if (md > 3'd5)                   return "R10";
    if (a >= 12'h30C && a <= 12'h30F) return "R2";
    if (a >= 12'h60C && a <= 12'h60F) return "R3";
    if (a >= 12'h10C && a <= 12'h10F) return (md == 3'd5) ? "R6" : "R5";
    return "R9";
  endfunction

  // One clock: drive, compare against the model, then advance the model.
  task automatic step(input logic [11:0] a, input logic [63:0] wd, input bit we,
                      input logic [2:0] md, input logic [2:0] qm,
                      input logic [1:0] qi, input string tag);
    int          i;
    bit          in_m, in_h, in_s, high, sup, gst_s, gst_u, exp_ill, exp_vir;
    logic [63:0] exp_rd, exp_al, sx;
    @(negedge clk);
    csr_addr = a; csr_wdata = wd; csr_we = we; priv_mode = md;
    qry_mode = qm; qry_idx = qi;
    #1;
    i     = int'(a[1:0]);
    in_m  = (a[11:2] == 10'h0C3);
    in_h  = (a[11:2] == 10'h183);
    in_s  = (a[11:2] == 10'h043);
    high  = (md == 3'd3);
    sup   = (md == 3'd1) || (md == 3'd2);
    gst_s = (md == 3'd5);
    gst_u = (md == 3'd4);
    exp_ill = 0; exp_vir = 0; exp_rd = 64'd0;
    if (in_m) begin
      exp_ill = !high;
      exp_rd  = mdl_m[i];
    end else if (in_h) begin
      exp_vir = gst_s || gst_u;
      exp_ill = !(high || sup || gst_s || gst_u);
      exp_rd  = mdl_h[i] & mdl_m[i];
    end else if (in_s) begin
      exp_vir = gst_u;
      exp_ill = !(high || sup || gst_s || gst_u);
      exp_rd  = {32'd0, mdl_s[i] & mdl_m[i][31:0] & (gst_s ? mdl_h[i][31:0] : 32'hFFFF_FFFF)};
    end
    if (exp_ill || exp_vir) exp_rd = 64'd0;
    sx = {32'd0, mdl_s[qi]};
    case (qm)
      3'd3:       exp_al = '1;
      3'd1, 3'd2: exp_al = mdl_m[qi];
      3'd5:       exp_al = mdl_m[qi] & mdl_h[qi];
      3'd4:       exp_al = mdl_m[qi] & mdl_h[qi] & sx;
      default:    exp_al = mdl_m[qi] & sx;
    endcase
    chk(tag, "rdata",   csr_rdata,   exp_rd);
    chk(tag, "illegal", {63'd0, csr_illegal}, {63'd0, exp_ill});
    chk(tag, "virtual", {63'd0, csr_virtual}, {63'd0, exp_vir});
    chk("R8", "allow",  qry_allow,   exp_al);
    @(posedge clk);
    if (we && !exp_ill && !exp_vir) begin
      if (in_m) mdl_m[i] = wd;
      else if (in_h) mdl_h[i] = wd & mdl_m[i];
      else if (in_s) mdl_s[i] = wd[31:0] & mdl_m[i][31:0] &
                                (gst_s ? mdl_h[i][31:0] : 32'hFFFF_FFFF);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) begin mdl_m[k] = '0; mdl_h[k] = '0; mdl_s[k] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: every register zero after reset; queries for all modes
    for (int k = 0; k < 4; k++) begin
      step(12'h30C + 12'(k), 64'd0, 0, 3'd3, 3'd0, 2'(k), "R1");
      step(12'h60C + 12'(k), 64'd0, 0, 3'd3, 3'd4, 2'(k), "R1");
      step(12'h10C + 12'(k), 64'd0, 0, 3'd3, 3'd3, 2'(k), "R1");
    end

    // R2: machine tier from M, then rejected from lower modes
    step(12'h30C, 64'hFFFF_FFFF_FFFF_FFFF, 1, 3'd3, 3'd1, 2'd0, "R2");
    step(12'h30D, 64'hF0F0_F0F0_0FF0_0FF0, 1, 3'd3, 3'd1, 2'd1, "R2");
    step(12'h30E, 64'h8000_0000_1234_5678, 1, 3'd3, 3'd1, 2'd2, "R2");
    step(12'h30F, 64'h0000_0000_0000_00FF, 1, 3'd3, 3'd1, 2'd3, "R2");
    step(12'h30C, 64'd0, 1, 3'd2, 3'd1, 2'd0, "R2");
    step(12'h30D, 64'd0, 1, 3'd5, 3'd1, 2'd1, "R2");
    step(12'h30C, 64'd0, 0, 3'd3, 3'd1, 2'd0, "R2");
    step(12'h30D, 64'd0, 0, 3'd3, 3'd1, 2'd1, "R2");

    // R3: hypervisor tier masked by machine tier on write and read
    step(12'h60C, 64'h5555_AAAA_5555_AAAA, 1, 3'd2, 3'd5, 2'd0, "R3");
    step(12'h60D, 64'hFFFF_FFFF_FFFF_FFFF, 1, 3'd1, 3'd5, 2'd1, "R3");
    step(12'h60E, 64'hFFFF_FFFF_FFFF_FFFF, 1, 3'd3, 3'd5, 2'd2, "R3");
    step(12'h60F, 64'h0F0F_0F0F_0F0F_0F0F, 1, 3'd2, 3'd5, 2'd3, "R3");
    step(12'h60D, 64'd0, 0, 3'd2, 3'd5, 2'd1, "R3");

    // R4: guest and user attempts on the hypervisor tier
    step(12'h60C, 64'd0, 1, 3'd5, 3'd5, 2'd0, "R4");
    step(12'h60C, 64'd0, 1, 3'd4, 3'd5, 2'd0, "R4");
    step(12'h60C, 64'd0, 1, 3'd0, 3'd5, 2'd0, "R4");
    step(12'h60C, 64'd0, 0, 3'd2, 3'd5, 2'd0, "R4");

    // R5 / R6: supervisor tier from S and from VS with the same data
    step(12'h10C, 64'hFFFF_FFFF_FFFF_FFFF, 1, 3'd1, 3'd0, 2'd0, "R5");
    step(12'h10C, 64'd0, 0, 3'd1, 3'd0, 2'd0, "R5");
    step(12'h10C, 64'd0, 0, 3'd5, 3'd4, 2'd0, "R6");
    step(12'h10D, 64'hFFFF_FFFF_FFFF_FFFF, 1, 3'd5, 3'd4, 2'd1, "R6");
    step(12'h10D, 64'd0, 0, 3'd2, 3'd4, 2'd1, "R6");
    step(12'h10E, 64'hFFFF_FFFF_FFFF_FFFF, 1, 3'd2, 3'd4, 2'd2, "R5");
    step(12'h10F, 64'hFFFF_FFFF_FFFF_FFFF, 1, 3'd5, 3'd4, 2'd3, "R6");

    // R7: user and guest-user attempts on the supervisor tier
    step(12'h10C, 64'd0, 1, 3'd0, 3'd0, 2'd0, "R7");
    step(12'h10C, 64'd0, 1, 3'd4, 3'd4, 2'd0, "R7");
    step(12'h10C, 64'd0, 0, 3'd1, 3'd0, 2'd0, "R7");

    // R3 / R5: clearing a machine bit hides lower tiers without a rewrite
    step(12'h30C, 64'h7FFF_FFFF_FFFF_FFFE, 1, 3'd3, 3'd4, 2'd0, "R3");
    step(12'h60C, 64'd0, 0, 3'd3, 3'd4, 2'd0, "R3");
    step(12'h10C, 64'd0, 0, 3'd1, 3'd0, 2'd0, "R5");
    step(12'h30C, 64'hFFFF_FFFF_FFFF_FFFF, 1, 3'd3, 3'd4, 2'd0, "R3");
    step(12'h10C, 64'd0, 0, 3'd1, 3'd0, 2'd0, "R5");

    // R8: query sweep over every mode code and index
    for (int q = 0; q < 8; q++)
      for (int k = 0; k < 4; k++)
        step(12'h000, 64'd0, 0, 3'd3, 3'(q), 2'(k), "R8");

    // R9: unmapped neighbours; writes must not land
    step(12'h10B, 64'hFFFF_FFFF_FFFF_FFFF, 1, 3'd3, 3'd0, 2'd0, "R9");
    step(12'h310, 64'hFFFF_FFFF_FFFF_FFFF, 1, 3'd3, 3'd0, 2'd0, "R9");
    step(12'h60B, 64'hFFFF_FFFF_FFFF_FFFF, 1, 3'd0, 3'd0, 2'd0, "R9");
    step(12'h30F, 64'd0, 0, 3'd3, 3'd0, 2'd3, "R9");

    // R10: codes 6 and 7 act as user mode
    step(12'h10C, 64'd0, 1, 3'd6, 3'd6, 2'd0, "R10");
    step(12'h60D, 64'd0, 1, 3'd7, 3'd7, 2'd1, "R10");
    step(12'h30E, 64'd0, 1, 3'd6, 3'd7, 2'd2, "R10");

    // Mixed traffic over all modes and windows
    for (int n = 0; n < 600; n++) begin
      logic [11:0] a;
      logic [2:0]  md;
      case ($urandom % 4)
        0: a = 12'h30C + 12'($urandom % 4);
        1: a = 12'h60C + 12'($urandom % 4);
        2: a = 12'h10C + 12'($urandom % 4);
        default: a = 12'h100 + 12'($urandom % 64);
      endcase
      md = ((n % 5) == 0) ? 3'd3 : 3'($urandom % 8);
      step(a, {$urandom, $urandom}, 1'($urandom % 2), md,
           3'($urandom % 8), 2'($urandom % 4), tag_of(a, md));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule